// File: doc/BRIEF.md
# Bus Transaction Filtering Event Counter

This block watches a stream of bus request descriptors and counts the ones that satisfy a programmable filter. Each descriptor arrives with a valid strobe and carries five things: a 5-bit request-type code, a write flag (clear means read), a one-hot memory-class vector, a flag saying the request came from this agent, and a prefetch flag. A 32-bit control word holds the filter. Its upper seven bits must carry the event code 7'h03 before anything is counted, and the sixteen bits below them form the selection mask.

Two filter equations are available, chosen by a mode pin. The strict equation requires every category to match. The legacy equation joins request type, direction and memory class with OR, and then requires the source agent to match. An edge-only option turns level counting into transition counting, so a match held over several cycles advances the counter once. The count is always visible on an output port and is zeroed by a synchronous clear.

Top module: `busEvtCounter`

## Requirements
- R1: The counter advances only while control bits [31:25] equal 7'h03. Any other value there leaves the count unchanged.
- R2: The request type matches when the descriptor's 5-bit code equals control bits [13:9].
- R3: Direction matches when control bit 14 is set and the descriptor is a read (write flag 0), or when control bit 15 is set and it is a write (write flag 1).
- R4: Memory class is a one-hot vector (bit 0 uncacheable, 1 write-combining, 2 write-through, 3 write-protected, 4 write-back). It matches when it ANDs to nonzero with control bits [20:16], where bit 16 pairs with class bit 0.
- R5: Source matches when control bit 22 is set and the own-agent flag is 1, or when control bit 23 is set and the flag is 0.
- R6: A descriptor with the prefetch flag set never matches while control bit 24 is 0. With bit 24 set, prefetch descriptors are filtered like any other.
- R7: With the mode pin at 0 (strict), a valid descriptor matches only if request type, direction, memory class and source all match.
- R8: With the mode pin at 1 (legacy), a valid descriptor matches if (request type or direction or memory class matches) and source matches. The memory-class term is forced false whenever control bit 14 or 15 is set.
- R9: With edge-only set, the counter advances once for each cycle whose match is true after a cycle whose match was false. A match held over several cycles therefore counts once.
- R10: The counter is CntWidth bits wide (default 40) and wraps from all-ones to zero.
- R11: A clear zeroes the count on the next edge and takes priority over an increment in the same cycle.
- R12: After reset the count is zero. In level mode it rises by exactly one, one edge after each cycle whose valid descriptor matches, and never by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 32 | Event code and selection mask |
| legacyMode | input | 1 | 0 = strict equation, 1 = legacy equation |
| edgeOnly | input | 1 | Count false-to-true transitions of the match only |
| txnValid | input | 1 | Descriptor present this cycle |
| txnReqType | input | 5 | Request-type code |
| txnIsWrite | input | 1 | 1 = write, 0 = read |
| txnMemClass | input | 5 | One-hot memory class |
| txnFromSelf | input | 1 | Issued by this agent |
| txnPrefetch | input | 1 | Prefetch request |
| cntClear | input | 1 | Synchronous clear of the count |
| countValue | output | CntWidth (40) | Current count |

## Verification
Directed descriptors each break exactly one category of an otherwise full match: request code, direction, memory class, source or prefetch. The count then shows which term each equation actually requires. Legacy-mode cases pit a memory-class hit against a set direction bit, which separates the override rule from a plain OR. Held matches run with and without edge-only to tell transition counting from level counting. A clear arriving together with a match, and a run long enough to wrap a narrowed counter, cover the priority and width rules. A long run of seeded random descriptors, with the request code drawn from a small range so that matches are frequent, compares the count every cycle against a bench model across both modes and edge settings.

// File: rtl/busEvtPkg.sv
package busEvtPkg;
  localparam int SelLsb     = 25;
  localparam int SelWidth   = 7;
  localparam int MaskLsb    = 9;
  localparam int MaskWidth  = 16;
  localparam int ReqTypeW   = 5;
  localparam int NumMemCls  = 5;
  localparam logic [SelWidth-1:0] SelCode = 7'h03;

  // positions inside the 16-bit mask
  localparam int MReqLsb    = 0;
  localparam int MRead      = 5;
  localparam int MWrite     = 6;
  localparam int MMemLsb    = 7;
  localparam int MSelf      = 13;
  localparam int MOther     = 14;
  localparam int MPrefetch  = 15;

  typedef struct packed {
    logic incr;
    logic clear;
  } cntStrobe_t;
endpackage

// File: rtl/busEvtMatch.sv
module busEvtMatch
  import busEvtPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [31:0]          ctrlWord,
  input  logic                 legacyMode,
  input  logic                 edgeOnly,
  input  logic                 txnValid,
  input  logic [ReqTypeW-1:0]  txnReqType,
  input  logic                 txnIsWrite,
  input  logic [NumMemCls-1:0] txnMemClass,
  input  logic                 txnFromSelf,
  input  logic                 txnPrefetch,
  input  logic                 cntClear,
  output cntStrobe_t           strobe
);
  logic [MaskWidth-1:0] mask;
  logic [SelWidth-1:0]  selField;
  logic [NumMemCls-1:0] memHitVec;
  logic reqHit, dirHit, memHit, srcHit, pfOk, selOk;
  logic dirBitsSet, strictHit, legacyHit, matchNow, matchPrev;
  logic unusedBits;

  assign mask     = ctrlWord[MaskLsb +: MaskWidth];
  assign selField = ctrlWord[SelLsb +: SelWidth];
  assign unusedBits = ^{ctrlWord[MaskLsb-1:0], mask[12]};

  genvar gi;
  generate
    for (gi = 0; gi < NumMemCls; gi++) begin : g_memcls
      assign memHitVec[gi] = txnMemClass[gi] & mask[MMemLsb + gi];
    end
  endgenerate

  assign selOk      = (selField == SelCode);
  assign reqHit     = (txnReqType == mask[MReqLsb +: ReqTypeW]);
  assign dirHit     = (mask[MRead] & ~txnIsWrite) | (mask[MWrite] & txnIsWrite);
  assign memHit     = |memHitVec;
  assign srcHit     = (mask[MSelf] & txnFromSelf) | (mask[MOther] & ~txnFromSelf);
  assign pfOk       = ~txnPrefetch | mask[MPrefetch];
  assign dirBitsSet = mask[MRead] | mask[MWrite];

  assign strictHit = reqHit & dirHit & memHit & srcHit;
  assign legacyHit = (reqHit | dirHit | (memHit & ~dirBitsSet)) & srcHit;

  always_comb begin
    matchNow = txnValid & selOk & pfOk;
    if (legacyMode) matchNow = matchNow & legacyHit;
    else            matchNow = matchNow & strictHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= matchNow;
  end

  always_comb begin
    strobe.clear = cntClear;
    strobe.incr  = edgeOnly ? (matchNow & ~matchPrev) : matchNow;
  end
endmodule

// File: rtl/busEvtDatapath.sv
module busEvtDatapath
  import busEvtPkg::*;
#(
  parameter int CntWidth = 40
)(
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobe_t          strobe,
  output logic [CntWidth-1:0] countValue
);
  localparam logic [CntWidth-1:0] One = CntWidth'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             countValue <= '0;
    else if (strobe.clear) countValue <= '0;
    else if (strobe.incr)  countValue <= countValue + One;
  end
endmodule

// File: rtl/busEvtCounter.sv
module busEvtCounter
  import busEvtPkg::*;
#(
  parameter int CntWidth = 40
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         ctrlWord,
  input  logic                legacyMode,
  input  logic                edgeOnly,
  input  logic                txnValid,
  input  logic [4:0]          txnReqType,
  input  logic                txnIsWrite,
  input  logic [4:0]          txnMemClass,
  input  logic                txnFromSelf,
  input  logic                txnPrefetch,
  input  logic                cntClear,
  output logic [CntWidth-1:0] countValue
);
  cntStrobe_t strobe;

  busEvtMatch u_match (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .legacyMode(legacyMode),
    .edgeOnly(edgeOnly), .txnValid(txnValid), .txnReqType(txnReqType),
    .txnIsWrite(txnIsWrite), .txnMemClass(txnMemClass),
    .txnFromSelf(txnFromSelf), .txnPrefetch(txnPrefetch),
    .cntClear(cntClear), .strobe(strobe)
  );

  busEvtDatapath #(.CntWidth(CntWidth)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countValue(countValue)
  );
endmodule

// File: rtl/busEvtChecker.sv
module busEvtChecker #(
  parameter int CntWidth = 40
)(
  input logic                clk,
  input logic                rstN,
  input logic [31:0]         ctrlWord,
  input logic                txnValid,
  input logic                cntClear,
  input logic [CntWidth-1:0] countValue
);
  localparam logic [CntWidth-1:0] One = CntWidth'(1);

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> (countValue == '0));

  assert_single_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> (countValue == $past(countValue)) ||
                  (countValue == $past(countValue) + One));

  assert_code_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!cntClear && ctrlWord[31:25] != 7'h03) |=> $stable(countValue));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cntClear && !txnValid) |=> $stable(countValue));
endmodule

bind busEvtCounter busEvtChecker #(.CntWidth(CntWidth)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .txnValid(txnValid),
  .cntClear(cntClear), .countValue(countValue)
);

// File: tb/tb_busEvtCounter.sv
module tb_busEvtCounter;
  localparam int ClkPeriod = 10;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic legacyMode = 1'b0, edgeOnly = 1'b0, txnValid = 1'b0;
  logic [4:0] txnReqType = '0, txnMemClass = '0;
  logic txnIsWrite = 1'b0, txnFromSelf = 1'b0, txnPrefetch = 1'b0, cntClear = 1'b0;
  logic [CW-1:0] countValue;

  int errors = 0, checks = 0;
  logic [CW-1:0] expCount = '0;
  logic expPrev = 1'b0;

  busEvtCounter #(.CntWidth(CW)) dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .legacyMode(legacyMode),
    .edgeOnly(edgeOnly), .txnValid(txnValid), .txnReqType(txnReqType),
    .txnIsWrite(txnIsWrite), .txnMemClass(txnMemClass),
    .txnFromSelf(txnFromSelf), .txnPrefetch(txnPrefetch),
    .cntClear(cntClear), .countValue(countValue)
  );

  always #(ClkPeriod/2) clk = ~clk;

  initial begin
    #(ClkPeriod * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] mkCtrl(input logic [6:0] code, input logic [15:0] m);
    return {code, m, 9'b0};
  endfunction

  function automatic logic modelMatch(
    input logic [31:0] c, input logic leg, input logic v, input logic [4:0] rt,
    input logic wr, input logic [4:0] mem, input logic self, input logic pf);
    logic [15:0] m;
    logic rq, dr, mm, sr;
    m  = c[24:9];
    rq = (rt == m[4:0]);
    dr = (m[5] && !wr) || (m[6] && wr);
    mm = (mem & m[11:7]) != 5'b0;
    sr = (m[13] && self) || (m[14] && !self);
    if (!v || c[31:25] != 7'h03 || (pf && !m[15])) return 1'b0;
    if (leg) return (rq || dr || (mm && !(m[5] || m[6]))) && sr;
    return rq && dr && mm && sr;
  endfunction

  task automatic check(input string label, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", label, got, exp);
    end
  endtask

  // drive at negedge, update model at posedge, compare just after it
  task automatic step(input bit doCheck, input string label);
    logic m, inc;
    @(posedge clk);
    m   = modelMatch(ctrlWord, legacyMode, txnValid, txnReqType, txnIsWrite,
                     txnMemClass, txnFromSelf, txnPrefetch);
    inc = edgeOnly ? (m && !expPrev) : m;
    expPrev = m;
    if (cntClear) expCount = '0;
    else if (inc) expCount = expCount + CW'(1);
    #1;
    if (doCheck) check(label, countValue, expCount);
    @(negedge clk);
  endtask

  task automatic setTxn(input logic v, input logic [4:0] rt, input logic wr,
                        input logic [4:0] mem, input logic self, input logic pf);
    txnValid = v; txnReqType = rt; txnIsWrite = wr;
    txnMemClass = mem; txnFromSelf = self; txnPrefetch = pf;
  endtask

  // mask: req=00001, read, UC, self
  localparam logic [15:0] BaseMask = 16'h2000 | 16'h0080 | 16'h0020 | 16'h0001;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12 reset", countValue, '0);
    rstN = 1'b1;
    @(negedge clk);

    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00001, 0, 5'b00001, 1, 0);
    step(1, "R7 strict full match");
    ctrlWord = mkCtrl(7'h04, BaseMask);
    step(1, "R1 wrong event code");
    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00010, 0, 5'b00001, 1, 0);
    step(1, "R2 request code mismatch");
    setTxn(1, 5'b00001, 1, 5'b00001, 1, 0);
    step(1, "R3 write with read-only bit");
    ctrlWord = mkCtrl(7'h03, BaseMask | 16'h0040);
    step(1, "R3 write with write bit");
    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00001, 0, 5'b10000, 1, 0);
    step(1, "R4 write-back class not selected");
    ctrlWord = mkCtrl(7'h03, BaseMask | 16'h0800);
    step(1, "R4 write-back class selected");
    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00001, 0, 5'b00001, 0, 0);
    step(1, "R5 other agent not selected");
    ctrlWord = mkCtrl(7'h03, (BaseMask & ~16'h2000) | 16'h4000);
    step(1, "R5 other agent selected");
    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00001, 0, 5'b00001, 1, 1);
    step(1, "R6 prefetch excluded");
    ctrlWord = mkCtrl(7'h03, BaseMask | 16'h8000);
    step(1, "R6 prefetch included");

    legacyMode = 1'b1;
    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00111, 0, 5'b00010, 1, 0);
    step(1, "R8 legacy direction alone");
    ctrlWord = mkCtrl(7'h03, 16'h2000 | 16'h0040 | 16'h0080 | 16'h0001);
    setTxn(1, 5'b00111, 0, 5'b00001, 1, 0);
    step(1, "R8 legacy memory ignored with direction bit");
    ctrlWord = mkCtrl(7'h03, 16'h2000 | 16'h0080 | 16'h0001);
    step(1, "R8 legacy memory alone");
    setTxn(1, 5'b00111, 0, 5'b00001, 0, 0);
    step(1, "R8 legacy source required");
    legacyMode = 1'b0;

    ctrlWord = mkCtrl(7'h03, BaseMask);
    setTxn(1, 5'b00001, 0, 5'b00001, 1, 0);
    edgeOnly = 1'b1;
    for (int i = 0; i < 4; i++) step(1, "R9 held match edge mode");
    setTxn(0, 5'b00001, 0, 5'b00001, 1, 0);
    step(1, "R9 gap");
    setTxn(1, 5'b00001, 0, 5'b00001, 1, 0);
    step(1, "R9 second edge");
    edgeOnly = 1'b0;
    for (int i = 0; i < 3; i++) step(1, "R12 held match level mode");

    cntClear = 1'b1;
    step(1, "R11 clear beats increment");
    cntClear = 1'b0;

    for (int i = 0; i < (1 << CW) - 1; i++) step(0, "");
    check("R10 all ones before wrap", countValue, {CW{1'b1}});
    step(1, "R10 wrap to zero");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] m;
      m = 16'($urandom);
      m[4:0] = 5'($urandom % 4);
      ctrlWord   = mkCtrl(($urandom % 8 == 0) ? 7'($urandom) : 7'h03, m);
      legacyMode = 1'($urandom);
      if (i % 200 == 0) edgeOnly = 1'($urandom);
      cntClear   = ($urandom % 50 == 0);
      setTxn(($urandom % 4 != 0), 5'($urandom % 4), 1'($urandom),
             5'(1 << ($urandom % 5)), 1'($urandom), ($urandom % 4 == 0));
      step(1, "R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule